// File: doc/BRIEF.md
# Cascadable Dual Event Counter

This block counts rising edges on two asynchronous event inputs, a low-side input and a high-side input. It holds two 8-bit count registers. A channel-select bit sets how they relate. When the bit is clear, the two registers form one 16-bit counter: the low-side input drives the low register, and each wrap of the low register advances the high register. When the bit is set, each register counts events on its own input, and neither affects the other.

Each event input passes through a two-flop synchronizer and a rising-edge detector. Every edge therefore becomes one count pulse in the system clock domain, however long the input stays high.

Software reaches the block through a single-cycle register port. The port gives access to a control/status byte and to both count registers. Each counter has an enable bit. Each counter also has a wrap flag that software clears with a two-step handshake: first read the flag as 1, then write 0 to it.

Top module: `evc_dual_top`

## Requirements
- R1: After reset, the control byte (address 0) reads 0x00, and both count registers (address 1 = low, address 2 = high) read 0x00. Address 3 reads 0x00. The block therefore starts in cascaded mode with both counters disabled.
- R2: Control byte layout:
  - bit0 enables the low counter;
  - bit1 enables the high counter;
  - bit2 selects split mode when 1;
  - bit3 is a spare bit;
  - bit6 is the low wrap flag;
  - bit7 is the high wrap flag.

  In cascaded mode (bit2 = 0), each low-side event increments the low counter, and events on the high-side input are ignored.
- R3: In cascaded mode with the high counter enabled, a low-counter wrap from 0xFF to 0x00 increments the high counter in the same cycle.
- R4: In split mode, each counter increments on events at its own input, and a low-counter wrap does not change the high counter.
- R5: While a counter's enable bit is 0, its events are ignored and its value is held.
- R6: The low wrap flag is set when the low counter wraps from 0xFF to 0x00 by counting. The high wrap flag is set when the high counter wraps the same way.
- R7: Writing 0 to a set wrap flag clears it only if a read of the control byte has returned that flag as 1 beforehand. Without that read, the flag stays set. Writing 1 to a flag never sets it.
- R8: If a wrap sets a flag in the same cycle as a valid clear of that flag, the flag stays set.
- R9: A write to a count register loads the written value. This overrides any increment in that same cycle.
- R10: The spare bit 3 reads back what was written to it and has no effect on counting.
- R11: Each rising edge of an event input produces exactly one count. The new value appears after the third rising clock edge that follows the input's rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_lo_i | input | 1 | Asynchronous low-side event input |
| ev_hi_i | input | 1 | Asynchronous high-side event input |
| addr_i | input | 2 | Register address: 0 control, 1 low count, 2 high count |
| wr_en_i | input | 1 | Write strobe, one cycle |
| rd_en_i | input | 1 | Read strobe, one cycle; arms flag clearing |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register (combinational) |

## Verification
The counting path is exercised with the following input patterns:
- Bursts on the low-side input alone, which show that basic counting and edge detection work.
- Events on the high-side input while in cascaded mode, which must change nothing. This separates the two ways the high counter can be driven.
- Bursts that cross 0xFF in both modes, which show whether the carry reaches the high counter only when cascaded, and whether the flags set.
- Events while the enables are clear, which show whether holding works independently of the mode.
- Writes and clears timed to land in the exact cycle of a count pulse, which decide the override and set-wins priorities.
- A long-held input, whose result separates edge counting from level counting.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int CTRL_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_LO   = 2'd1;
    localparam logic [1:0] ADDR_HI   = 2'd2;

    localparam int BIT_CEN_LO = 0;
    localparam int BIT_CEN_HI = 1;
    localparam int BIT_SPLIT  = 2;
    localparam int BIT_SPARE  = 3;
    localparam int BIT_WRAP_LO = 6;
    localparam int BIT_WRAP_HI = 7;

    localparam int NUM_CH = 2;
    localparam int CH_LO  = 0;
    localparam int CH_HI  = 1;

    typedef struct packed {
        logic cen_lo;
        logic cen_hi;
        logic split;
        logic spare;
    } ctrl_t;
endpackage

// File: rtl/evc_edge_sync.sv
module evc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic pulse_o
);
    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.chain = {st_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Synchronized level is at index STAGES-1; index STAGES holds its previous value.
    assign pulse_o = st_q.chain[STAGES-1] & ~st_q.chain[STAGES];
endmodule

// File: rtl/evc_flag.sv
module evc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic clr_req_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (clr_req_i && st_q.armed) begin
            st_d.armed = 1'b0;
            st_d.flag  = 1'b0;
        end
        if (set_i) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/evc_dual_top.sv
module evc_dual_top
    import evc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_lo_i,
    input  logic             ev_hi_i,
    input  logic [1:0]       addr_i,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] rdata_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] cnt_lo;
        logic [CNT_W-1:0] cnt_hi;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NUM_CH-1:0] ev_async;
    logic [NUM_CH-1:0] ev_pulse;
    logic [NUM_CH-1:0] wrap;
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] flag_clr;

    logic wr_ctrl, wr_lo, wr_hi, rd_ctrl;
    logic lo_inc, hi_src, hi_inc;

    assign ev_async[CH_LO] = ev_lo_i;
    assign ev_async[CH_HI] = ev_hi_i;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam int FBIT = (g == CH_LO) ? BIT_WRAP_LO : BIT_WRAP_HI;

            evc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk     (clk),
                .rst_n   (rst_n),
                .async_i (ev_async[g]),
                .pulse_o (ev_pulse[g])
            );

            assign flag_clr[g] = wr_ctrl && !wdata_i[FBIT];

            evc_flag u_flag (
                .clk       (clk),
                .rst_n     (rst_n),
                .set_i     (wrap[g]),
                .rd_i      (rd_ctrl),
                .clr_req_i (flag_clr[g]),
                .flag_o    (flag[g])
            );
        end
    endgenerate

    assign wr_ctrl = wr_en_i && (addr_i == ADDR_CTRL);
    assign wr_lo   = wr_en_i && (addr_i == ADDR_LO);
    assign wr_hi   = wr_en_i && (addr_i == ADDR_HI);
    assign rd_ctrl = rd_en_i && (addr_i == ADDR_CTRL);

    always_comb begin
        st_d = st_q;

        lo_inc         = st_q.ctrl.cen_lo && ev_pulse[CH_LO];
        wrap[CH_LO]    = lo_inc && (st_q.cnt_lo == CNT_MAX) && !wr_lo;
        hi_src         = st_q.ctrl.split ? ev_pulse[CH_HI] : wrap[CH_LO];
        hi_inc         = st_q.ctrl.cen_hi && hi_src;
        wrap[CH_HI]    = hi_inc && (st_q.cnt_hi == CNT_MAX) && !wr_hi;

        if (wr_ctrl) begin
            st_d.ctrl.cen_lo = wdata_i[BIT_CEN_LO];
            st_d.ctrl.cen_hi = wdata_i[BIT_CEN_HI];
            st_d.ctrl.split  = wdata_i[BIT_SPLIT];
            st_d.ctrl.spare  = wdata_i[BIT_SPARE];
        end

        if (wr_lo)       st_d.cnt_lo = wdata_i;
        else if (lo_inc) st_d.cnt_lo = st_q.cnt_lo + CNT_ONE;

        if (wr_hi)       st_d.cnt_hi = wdata_i;
        else if (hi_inc) st_d.cnt_hi = st_q.cnt_hi + CNT_ONE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [CTRL_W-1:0] ctrl_rd;

    always_comb begin
        ctrl_rd              = '0;
        ctrl_rd[BIT_CEN_LO]  = st_q.ctrl.cen_lo;
        ctrl_rd[BIT_CEN_HI]  = st_q.ctrl.cen_hi;
        ctrl_rd[BIT_SPLIT]   = st_q.ctrl.split;
        ctrl_rd[BIT_SPARE]   = st_q.ctrl.spare;
        ctrl_rd[BIT_WRAP_LO] = flag[CH_LO];
        ctrl_rd[BIT_WRAP_HI] = flag[CH_HI];
        case (addr_i)
            ADDR_CTRL: rdata_o = CNT_W'(ctrl_rd);
            ADDR_LO:   rdata_o = st_q.cnt_lo;
            ADDR_HI:   rdata_o = st_q.cnt_hi;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/evc_dual_chk.sv
module evc_dual_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [1:0]   addr,
    input logic [W-1:0] wdata,
    input logic [W-1:0] cnt_lo,
    input logic [W-1:0] cnt_hi,
    input logic         flag_lo,
    input logic         pulse_lo,
    input logic         pulse_hi,
    input logic         cen_lo,
    input logic         split
);
    logic wr_lo, wr_hi, wr_ctrl;
    assign wr_lo   = wr_en && (addr == 2'd1);
    assign wr_hi   = wr_en && (addr == 2'd2);
    assign wr_ctrl = wr_en && (addr == 2'd0);

    AST_LO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_lo |=> (cnt_lo == $past(cnt_lo)) || (cnt_lo == $past(cnt_lo) + 1'b1)); // R2
    AST_LO_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_lo && !wr_lo) |=> $stable(cnt_lo)); // R5
    AST_SPLIT_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (split && !pulse_hi && !wr_hi) |=> $stable(cnt_hi)); // R4
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cen_lo && pulse_lo && (cnt_lo == {W{1'b1}}) && !wr_lo) |=> flag_lo); // R6
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_lo && !(wr_ctrl && !wdata[6])) |=> flag_lo); // R7
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt_lo == $past(wdata))); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_lo |=> !pulse_lo); // R11
endmodule

bind evc_dual_top evc_dual_chk #(.W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .addr     (addr_i),
    .wdata    (wdata_i),
    .cnt_lo   (st_q.cnt_lo),
    .cnt_hi   (st_q.cnt_hi),
    .flag_lo  (flag[0]),
    .pulse_lo (ev_pulse[0]),
    .pulse_hi (ev_pulse[1]),
    .cen_lo   (st_q.ctrl.cen_lo),
    .split    (st_q.ctrl.split)
);

// File: tb/evc_dual_top_tb_top.sv
`timescale 1ns/1ps
module evc_dual_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_lo = 1'b0, ev_hi = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    always #5 clk = ~clk;

    evc_dual_top dut_i (
        .clk(clk), .rst_n(rst_n), .ev_lo_i(ev_lo), .ev_hi_i(ev_hi),
        .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .wdata_i(wdata), .rdata_o(rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
        logic [7:0] v;
        reg_rd(a, v);
        check(req, v, exp);
    endtask

    task automatic pulse_ev(input bit hi, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (hi) ev_hi = 1'b1; else ev_lo = 1'b1;
            repeat (4) @(negedge clk);
            if (hi) ev_hi = 1'b0; else ev_lo = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    // Clear both flags via read-then-write-0, leaving ctrl = c.
    task automatic clear_flags(input logic [7:0] c);
        logic [7:0] v;
        reg_rd(2'd0, v);
        reg_wr(2'd0, c & 8'h3F);
    endtask

    task automatic t_reset();
        expect_reg("R1 ctrl", 2'd0, 8'h00);
        expect_reg("R1 lo", 2'd1, 8'h00);
        expect_reg("R1 hi", 2'd2, 8'h00);
        expect_reg("R1 addr3", 2'd3, 8'h00);
    endtask

    task automatic t_cascade();
        reg_wr(2'd0, 8'h03);
        pulse_ev(1'b0, 3);
        expect_reg("R2 lo count", 2'd1, 8'h03);
        pulse_ev(1'b1, 2);
        expect_reg("R2 hi input ignored", 2'd2, 8'h00);
        expect_reg("R2 lo unchanged", 2'd1, 8'h03);
    endtask

    task automatic t_carry();
        reg_wr(2'd1, 8'hFE);
        reg_wr(2'd2, 8'h10);
        pulse_ev(1'b0, 2);
        expect_reg("R3 lo wrapped", 2'd1, 8'h00);
        expect_reg("R3 hi carried", 2'd2, 8'h11);
        clear_flags(8'h03);
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd2, 8'hFF);
        pulse_ev(1'b0, 1);
        expect_reg("R6 hi wrapped", 2'd2, 8'h00);
    endtask

    task automatic t_flags();
        // Flags set by previous wrap; no read since.
        reg_wr(2'd0, 8'h03);
        expect_reg("R7 no-read write0 keeps flags", 2'd0, 8'hC3);
        reg_wr(2'd0, 8'h03);
        expect_reg("R7 read-then-write0 clears", 2'd0, 8'h03);
        reg_wr(2'd0, 8'hC3);
        expect_reg("R7 write1 no set", 2'd0, 8'h03);
    endtask

    task automatic t_set_wins();
        logic [7:0] v;
        reg_wr(2'd1, 8'hFF);
        pulse_ev(1'b0, 1);
        reg_rd(2'd0, v);
        check("R6 lo flag set", v & 8'h40, 8'h40);
        reg_wr(2'd1, 8'hFF);
        @(negedge clk);
        ev_lo = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 2'd0; wdata = 8'h03; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        ev_lo = 1'b0;
        repeat (4) @(negedge clk);
        expect_reg("R8 set wins", 2'd0, 8'h43);
        expect_reg("R8 lo wrapped", 2'd1, 8'h00);
        clear_flags(8'h03);
        expect_reg("R8 later clear", 2'd0, 8'h03);
    endtask

    task automatic t_split();
        reg_wr(2'd0, 8'h07);
        reg_wr(2'd1, 8'hFF);
        reg_wr(2'd2, 8'h05);
        pulse_ev(1'b0, 1);
        expect_reg("R4 lo wrapped", 2'd1, 8'h00);
        expect_reg("R4 no carry", 2'd2, 8'h05);
        pulse_ev(1'b1, 2);
        expect_reg("R4 hi own input", 2'd2, 8'h07);
        expect_reg("R4 lo untouched", 2'd1, 8'h00);
        clear_flags(8'h07);
    endtask

    task automatic t_hold();
        reg_wr(2'd0, 8'h04);
        reg_wr(2'd1, 8'h33);
        reg_wr(2'd2, 8'h44);
        pulse_ev(1'b0, 2);
        pulse_ev(1'b1, 2);
        expect_reg("R5 lo held", 2'd1, 8'h33);
        expect_reg("R5 hi held", 2'd2, 8'h44);
        reg_wr(2'd0, 8'h01);
        reg_wr(2'd1, 8'hFF);
        pulse_ev(1'b0, 1);
        expect_reg("R5 lo counts", 2'd1, 8'h00);
        expect_reg("R5 hi held on carry", 2'd2, 8'h44);
        clear_flags(8'h01);
    endtask

    task automatic t_override();
        reg_wr(2'd0, 8'h05);
        reg_wr(2'd1, 8'h20);
        @(negedge clk);
        ev_lo = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        addr = 2'd1; wdata = 8'h40; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (3) @(negedge clk);
        ev_lo = 1'b0;
        repeat (4) @(negedge clk);
        expect_reg("R9 write overrides", 2'd1, 8'h40);
    endtask

    task automatic t_spare();
        reg_wr(2'd0, 8'h0D);
        expect_reg("R10 spare readback", 2'd0, 8'h0D);
        reg_wr(2'd1, 8'h10);
        reg_wr(2'd2, 8'h50);
        pulse_ev(1'b0, 2);
        expect_reg("R10 lo counts normally", 2'd1, 8'h12);
        expect_reg("R10 hi unchanged", 2'd2, 8'h50);
    endtask

    task automatic t_latency();
        reg_wr(2'd0, 8'h05);
        reg_wr(2'd1, 8'h00);
        addr = 2'd1;
        @(negedge clk);
        ev_lo = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #2 check("R11 not yet after 2 edges", rdata, 8'h00);
        @(posedge clk);
        #2 check("R11 counted after 3 edges", rdata, 8'h01);
        repeat (20) @(negedge clk);
        ev_lo = 1'b0;
        repeat (4) @(negedge clk);
        expect_reg("R11 long level one count", 2'd1, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cascade();
        t_carry();
        t_flags();
        t_set_wins();
        t_split();
        t_hold();
        t_override();
        t_spare();
        t_latency();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                failures++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule